// File: doc/BRIEF.md
# Timestamped Transmit Packet Scheduler

This block sits at the head of the transmit queue for host packets. It takes a stream of 32-bit words over a valid/ready handshake. Every packet has the same length: a header word, a timestamp word and then a payload area. The block reads the header and the timestamp and compares the timestamp with the free-running sample counter. From that result it holds the packet, plays its samples to the D/A output starting at the requested count, or throws the packet away because it arrived too late.

Samples leave one per sample-clock enable. Each sample appears as a one-clock strobe with its data. A packet on the reserved control channel is not played; its words are forwarded to a separate control port. The start and end flags in the header open and close a burst. While a burst is open, every enable that yields no sample raises an underrun pulse. Once a burst has closed, idle enables are silent. A discarded packet raises a one-cycle dropped pulse, which upstream logic folds into the next packet sent toward the host.

Top module: `txs_tx_sched`

## Requirements
- R1: A packet is PKT_WORDS words long. Word 0 is the header and word 1 is the timestamp. In the header, bits 8:0 give the payload length in bytes, bits 20:16 the channel, bit 28 the start-of-burst flag and bit 27 the end-of-burst flag. All other header bits are ignored.
- R2: For a timed packet, the first sample is taken on the sample enable during which time_now equals the timestamp. Its dac_strobe is seen one clock later.
- R3: A timestamp of 0xFFFFFFFF means "now". The packet plays from the next sample enable, with no time compare.
- R4: A packet is late when the wraparound-safe signed difference (time_now − timestamp) is greater than zero while it waits at the head. A late packet is consumed without any strobe, and drop_pulse is high for exactly one clock.
- R5: Samples leave in payload order, one per sample enable. A packet plays floor(length/4) samples. Pad words after the payload are consumed and never played.
- R6: A packet on channel 31 is never played. All of its PKT_WORDS words appear on ctrl_data with ctrl_valid. ctrl_sop marks the header word and ctrl_eop marks the last word.
- R7: While a burst opened by a start-flagged packet is active, each sample enable that produces no sample raises underrun_pulse for one clock.
- R8: The burst closes when the last sample of an end-flagged packet leaves; after that, idle enables raise no underrun. Within a burst, a following "now" packet continues on the very next enable, with no gap.
- R9: Under synchronous active-low reset, all output pulses are low, in_ready is high (awaiting a header) and any open burst is closed.
- R10: A zero-length packet plays no samples, raises no drop, and all of its words are consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | One-clock sample-clock enable; the sample counter advances after it |
| time_now | input | TS_W | Free-running sample counter |
| in_data | input | 32 | Packet word stream |
| in_valid | input | 1 | in_data holds a word |
| in_ready | output | 1 | Block takes the word this clock |
| dac_strobe | output | 1 | One sample is presented on dac_data |
| dac_data | output | 32 | Sample for the D/A converter |
| drop_pulse | output | 1 | A late packet was discarded |
| underrun_pulse | output | 1 | Enable without a sample inside a burst |
| ctrl_data | output | 32 | Forwarded control-channel word |
| ctrl_valid | output | 1 | ctrl_data holds a word |
| ctrl_sop | output | 1 | Forwarded word is a header |
| ctrl_eop | output | 1 | Forwarded word is the last of its packet |

## Verification
The bound checker watches the pulse discipline on every cycle. A strobe or an underrun only ever follows a sample enable. A strobe never coincides with an underrun, a drop or a forwarded control word. A drop never lasts two clocks. The bench scenarios cover what depends on packet history and on time. These include sample timing against the timestamp across the signed midpoint of the counter, the order of the data, the floor rounding of odd byte lengths, and back-to-back continuation within a burst. They also include the counting of underruns in an open burst and their silence once a burst has closed or after a reset.

// File: rtl/txs_pkg.sv
// Shared protocol constants and types for the transmit scheduler.
// Assumes a 32-bit word stream; header field positions are fixed by the
// host-side packet format and must not move.
package txs_pkg;

    localparam int WORD_W    = 32;
    localparam int LEN_LSB   = 0;
    localparam int LEN_W     = 9;
    localparam int CHAN_LSB  = 16;
    localparam int CHAN_W    = 5;
    localparam int EOB_BIT   = 27;
    localparam int SOB_BIT   = 28;
    localparam logic [CHAN_W-1:0] CTRL_CHAN = '1;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_TS,
        ST_WAIT,
        ST_PLAY,
        ST_SKIP,
        ST_CTRL
    } txs_state_e;

    typedef struct packed {
        logic sob;
        logic eob;
    } txs_flags_t;

endpackage

// File: rtl/txs_hdr_decode.sv
// Header word decoder. Pulls the burst flags and the control-channel match
// from the header and turns the byte length into whole 32-bit samples.
// The count is clamped to the payload area. Purely combinational; it
// assumes the caller applies it only to the header word.
module txs_hdr_decode
    import txs_pkg::*;
#(
    parameter int PAY_WORDS = 126,
    parameter int SAMP_W    = 7
) (
    input  logic [WORD_W-1:0] hdr_word,
    output txs_flags_t        flags,
    output logic              is_ctrl,
    output logic [SAMP_W-1:0] nsamp
);

    logic [LEN_W-1:0] len_bytes;
    logic [LEN_W-1:0] whole;
    logic             unused_hdr_bits;

    // extract fields
    always_comb begin
        len_bytes = hdr_word[LEN_LSB +: LEN_W];
        whole     = len_bytes >> 2;
        flags.sob = hdr_word[SOB_BIT];
        flags.eob = hdr_word[EOB_BIT];
        is_ctrl   = (hdr_word[CHAN_LSB +: CHAN_W] == CTRL_CHAN);
    end

    // clamp sample count to the payload area
    assign nsamp = (whole > LEN_W'(PAY_WORDS)) ? SAMP_W'(PAY_WORDS) : SAMP_W'(whole);

    // bits that carry no meaning toward the converter
    assign unused_hdr_bits = ^{hdr_word[WORD_W-1:SOB_BIT+1],
                               hdr_word[EOB_BIT-1:CHAN_LSB+CHAN_W],
                               hdr_word[CHAN_LSB-1:LEN_LSB+LEN_W]};

endmodule

// File: rtl/txs_time_cmp.sv
// Timestamp comparator. Uses a wraparound-safe signed difference of the
// sample counter and the packet timestamp. The all-ones timestamp is the
// reserved "now" value, which is never due and never late.
module txs_time_cmp #(
    parameter int TS_W = 32
) (
    input  logic [TS_W-1:0] now,
    input  logic [TS_W-1:0] ts,
    output logic            is_now,
    output logic            late,
    output logic            due
);

    logic [TS_W-1:0] diff;

    // signed distance of counter past the timestamp
    always_comb begin
        diff   = now - ts;
        is_now = &ts;
        late   = !is_now && !diff[TS_W-1] && (diff != '0);
        due    = !is_now && (diff == '0);
    end

endmodule

// File: rtl/txs_burst_track.sv
// Burst tracker. Opens a burst when a start-flagged packet begins playing.
// Closes it when an end-flagged packet has played its last sample. Inside
// a burst it flags every sample enable that produced no sample. A close
// takes priority over an open in the same clock.
module txs_burst_track (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic emit,
    input  logic open_evt,
    input  logic close_evt,
    output logic in_burst,
    output logic underrun_pulse
);

    // burst state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_burst <= 1'b0;
        else if (close_evt)
            in_burst <= 1'b0;
        else if (open_evt)
            in_burst <= 1'b1;
    end

    // underrun event on a starved enable inside a burst
    always_ff @(posedge clk) begin
        if (!rst_n)
            underrun_pulse <= 1'b0;
        else
            underrun_pulse <= sample_en && in_burst && !emit;
    end

endmodule

// File: rtl/txs_tx_sched.sv
// Timestamped transmit packet scheduler (top). Accepts fixed-length packets
// on a valid/ready word stream. It waits at the head of the queue until the
// timestamp is due, then plays one sample per sample enable. Late packets
// are discarded and control-channel packets are forwarded.
// Assumes PKT_WORDS >= 3 and that time_now advances only after sample_en.
module txs_tx_sched
    import txs_pkg::*;
#(
    parameter int PKT_WORDS = 128,
    parameter int TS_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic [TS_W-1:0]   time_now,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              dac_strobe,
    output logic [WORD_W-1:0] dac_data,
    output logic              drop_pulse,
    output logic              underrun_pulse,
    output logic [WORD_W-1:0] ctrl_data,
    output logic              ctrl_valid,
    output logic              ctrl_sop,
    output logic              ctrl_eop
);

    localparam int PAY_WORDS = PKT_WORDS - 2;
    localparam int SAMP_W    = $clog2(PAY_WORDS + 1);
    localparam int WCNT_W    = $clog2(PKT_WORDS + 1);

    txs_state_e        state;
    txs_flags_t        flags_q;
    txs_flags_t        dec_flags;
    logic              dec_ctrl;
    logic [SAMP_W-1:0] dec_nsamp;
    logic [SAMP_W-1:0] samp_left;
    logic [WCNT_W-1:0] word_left;
    logic [TS_W-1:0]   ts_q;
    logic              ts_now, ts_late, ts_due;
    logic              go, late_hit, accept, emit, last_samp, last_word;
    logic              open_evt, close_evt, in_burst;

    txs_hdr_decode #(
        .PAY_WORDS (PAY_WORDS),
        .SAMP_W    (SAMP_W)
    ) u_dec (
        .hdr_word (in_data),
        .flags    (dec_flags),
        .is_ctrl  (dec_ctrl),
        .nsamp    (dec_nsamp)
    );

    txs_time_cmp #(
        .TS_W (TS_W)
    ) u_cmp (
        .now    (time_now),
        .ts     (ts_q),
        .is_now (ts_now),
        .late   (ts_late),
        .due    (ts_due)
    );

    // release and discard decisions at the head of the queue
    always_comb begin
        late_hit = (state == ST_WAIT) && ts_late;
        go       = (state == ST_WAIT) && sample_en && !ts_late && (ts_now || ts_due);
    end

    // word acceptance per state
    always_comb begin
        unique case (state)
            ST_HDR, ST_TS, ST_SKIP, ST_CTRL: in_ready = 1'b1;
            ST_WAIT:                         in_ready = go && (samp_left != '0);
            ST_PLAY:                         in_ready = sample_en;
            default:                         in_ready = 1'b0;
        endcase
    end

    // handshake and end-of-count conditions
    always_comb begin
        accept    = in_valid && in_ready;
        emit      = accept && ((state == ST_WAIT) || (state == ST_PLAY));
        last_samp = emit && (samp_left == SAMP_W'(1));
        last_word = accept && (word_left == WCNT_W'(1));
    end

    // burst open/close events
    always_comb begin
        open_evt  = go && flags_q.sob;
        close_evt = flags_q.eob && (last_samp || (go && (samp_left == '0)));
    end

    // packet sequencer and word/sample counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HDR;
            flags_q   <= '0;
            samp_left <= '0;
            word_left <= '0;
            ts_q      <= '0;
        end else begin
            if (emit)
                samp_left <= samp_left - SAMP_W'(1);
            if (accept && (state != ST_HDR) && (state != ST_TS))
                word_left <= word_left - WCNT_W'(1);
            unique case (state)
                ST_HDR: if (accept) begin
                    flags_q   <= dec_flags;
                    samp_left <= dec_nsamp;
                    if (dec_ctrl) begin
                        word_left <= WCNT_W'(PKT_WORDS - 1);
                        state     <= ST_CTRL;
                    end else begin
                        state     <= ST_TS;
                    end
                end
                ST_TS: if (accept) begin
                    ts_q      <= in_data[TS_W-1:0];
                    word_left <= WCNT_W'(PAY_WORDS);
                    state     <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (late_hit)
                        state <= ST_SKIP;
                    else if (go) begin
                        if (samp_left == '0)
                            state <= ST_SKIP;
                        else if (last_samp)
                            state <= last_word ? ST_HDR : ST_SKIP;
                        else
                            state <= ST_PLAY;
                    end
                end
                ST_PLAY: if (last_samp)
                    state <= last_word ? ST_HDR : ST_SKIP;
                ST_SKIP, ST_CTRL: if (last_word)
                    state <= ST_HDR;
                default: state <= ST_HDR;
            endcase
        end
    end

    // converter output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_strobe <= 1'b0;
            dac_data   <= '0;
        end else begin
            dac_strobe <= emit;
            if (emit)
                dac_data <= in_data;
        end
    end

    // drop event and control forwarding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_pulse <= 1'b0;
            ctrl_valid <= 1'b0;
            ctrl_sop   <= 1'b0;
            ctrl_eop   <= 1'b0;
            ctrl_data  <= '0;
        end else begin
            drop_pulse <= late_hit;
            ctrl_valid <= accept && ((state == ST_CTRL) || ((state == ST_HDR) && dec_ctrl));
            ctrl_sop   <= accept && (state == ST_HDR) && dec_ctrl;
            ctrl_eop   <= last_word && (state == ST_CTRL);
            if (accept)
                ctrl_data <= in_data;
        end
    end

    txs_burst_track u_burst (
        .clk            (clk),
        .rst_n          (rst_n),
        .sample_en      (sample_en),
        .emit           (emit),
        .open_evt       (open_evt),
        .close_evt      (close_evt),
        .in_burst       (in_burst),
        .underrun_pulse (underrun_pulse)
    );

endmodule

// File: rtl/txs_tx_sched_chk.sv
// Cycle-level checker for the transmit scheduler, bound to its ports.
// Assumes only the port-level pulse contract; no internal state is read.
module txs_tx_sched_chk (
    input logic clk,
    input logic rst_n,
    input logic sample_en,
    input logic dac_strobe,
    input logic drop_pulse,
    input logic underrun_pulse,
    input logic ctrl_valid
);

    // R5: a sample only leaves in the clock after an enable
    p_strobe_after_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dac_strobe |-> $past(sample_en));

    // R7: underrun only on a starved enable, never with a sample
    p_underrun_starved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_pulse |-> ($past(sample_en) && !dac_strobe));

    // R4: a discard is a single-clock event
    p_drop_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |=> !drop_pulse);

    // R4: a discarded packet never plays alongside its drop
    p_drop_no_play_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> !dac_strobe);

    // R6: forwarded control words never coincide with a played sample
    p_ctrl_no_play_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_valid |-> !dac_strobe);

endmodule

bind txs_tx_sched txs_tx_sched_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_en      (sample_en),
    .dac_strobe     (dac_strobe),
    .drop_pulse     (drop_pulse),
    .underrun_pulse (underrun_pulse),
    .ctrl_valid     (ctrl_valid)
);

// File: tb/test_txs_tx_sched.sv
`timescale 1ns/1ps
// Bench: vector table of packets walked by one loop, then directed burst,
// underrun and reset tests. 16-word packets, enable every 24 clocks.
module test_txs_tx_sched;

    localparam int PKT_WORDS = 16;
    localparam int SE_PER    = 24;
    localparam int LOG_N     = 64;

    typedef struct packed {
        logic [1:0] kind;     // 0 timed, 1 now, 2 late, 3 control
        logic [7:0] delta;
        logic [8:0] len;
        logic       sob;
        logic       eob;
        logic [7:0] exp_n;
        logic       exp_drop;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 8'd0, 9'd16, 1'b1, 1'b1, 8'd4,  1'b0},
        '{2'd0, 8'd3, 9'd8,  1'b1, 1'b1, 8'd2,  1'b0},
        '{2'd0, 8'd0, 9'd4,  1'b1, 1'b1, 8'd1,  1'b0},
        '{2'd2, 8'd2, 9'd8,  1'b1, 1'b1, 8'd0,  1'b1},
        '{2'd3, 8'd0, 9'd12, 1'b0, 1'b0, 8'd0,  1'b0},
        '{2'd1, 8'd0, 9'd56, 1'b1, 1'b1, 8'd14, 1'b0},
        '{2'd1, 8'd0, 9'd0,  1'b1, 1'b1, 8'd0,  1'b0},
        '{2'd1, 8'd0, 9'd6,  1'b1, 1'b1, 8'd1,  1'b0},
        '{2'd2, 8'd1, 9'd4,  1'b0, 1'b0, 8'd0,  1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_en = 1'b0;
    logic [31:0] tnow = 32'h7FFF_FFF0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready, dac_strobe, drop_pulse, underrun_pulse;
    logic        ctrl_valid, ctrl_sop, ctrl_eop;
    logic [31:0] dac_data, ctrl_data;

    int checks = 0, errors = 0, cyc = 0, se_cnt = 0;
    int strobe_cnt = 0, drop_cnt = 0, under_cnt = 0;
    int ctrl_cnt = 0, sop_cnt = 0, eop_cnt = 0;
    logic [31:0] log_d [LOG_N];
    logic [31:0] log_t [LOG_N];

    txs_tx_sched #(.PKT_WORDS(PKT_WORDS), .TS_W(32)) i_txs_tx_sched (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .time_now(tnow),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .dac_strobe(dac_strobe), .dac_data(dac_data), .drop_pulse(drop_pulse),
        .underrun_pulse(underrun_pulse), .ctrl_data(ctrl_data),
        .ctrl_valid(ctrl_valid), .ctrl_sop(ctrl_sop), .ctrl_eop(ctrl_eop)
    );

    always #2.5 clk = ~clk;

    // sample enable and free-running counter
    always @(posedge clk) begin
        se_cnt    <= (se_cnt == SE_PER - 1) ? 0 : se_cnt + 1;
        sample_en <= (se_cnt == SE_PER - 1);
        tnow      <= tnow + {31'd0, sample_en};
    end

    // output monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (dac_strobe) begin
                if (strobe_cnt < LOG_N) begin
                    log_d[strobe_cnt] = dac_data;
                    log_t[strobe_cnt] = tnow - 32'd1;
                end
                strobe_cnt++;
            end
            if (drop_pulse)     drop_cnt++;
            if (underrun_pulse) under_cnt++;
            if (ctrl_valid)     ctrl_cnt++;
            if (ctrl_valid && ctrl_sop) sop_cnt++;
            if (ctrl_valid && ctrl_eop) eop_cnt++;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog (R5 progress): cycles %0d expected below %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R1: ignored header bits (31, 26:21, 12:9) are deliberately nonzero
    function automatic logic [31:0] mk_hdr(input logic sob, input logic eob,
                                          input logic [4:0] chan, input logic [8:0] len);
        return {1'b1, 2'b00, sob, eob, 6'h2A, chan, 3'b000, 4'h5, len};
    endfunction

    task automatic sync_enable();
        do @(negedge clk); while (sample_en !== 1'b1);
        @(negedge clk);
    endtask

    task automatic send_pkt(input logic [31:0] hdr, input logic [31:0] ts, input logic [7:0] tag);
        for (int w = 0; w < PKT_WORDS; w++) begin
            in_data  = (w == 0) ? hdr : (w == 1) ? ts : {tag, 24'(w - 2)};
            in_valid = 1'b1;
            while (in_ready !== 1'b1) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] ts;
        int s0, d0, u0, c0, p0, e0;

        // R9: reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 strobe after reset", {31'd0, dac_strobe}, 32'd0);
        check("R9 drop after reset", {31'd0, drop_pulse}, 32'd0);
        check("R9 underrun after reset", {31'd0, underrun_pulse}, 32'd0);
        check("R9 ctrl_valid after reset", {31'd0, ctrl_valid}, 32'd0);
        check("R9 ready after reset", {31'd0, in_ready}, 32'd1);

        // vector table walk
        for (int v = 0; v < NVEC; v++) begin
            sync_enable();
            s0 = strobe_cnt; d0 = drop_cnt; u0 = under_cnt;
            c0 = ctrl_cnt; p0 = sop_cnt; e0 = eop_cnt;
            case (VECS[v].kind)
                2'd1:    ts = 32'hFFFF_FFFF;
                2'd2:    ts = tnow - {24'd0, VECS[v].delta};
                default: ts = tnow + {24'd0, VECS[v].delta};
            endcase
            send_pkt(mk_hdr(VECS[v].sob, VECS[v].eob,
                            (VECS[v].kind == 2'd3) ? 5'd31 : 5'd2, VECS[v].len), ts, 8'(v));
            repeat (3) @(negedge clk);
            // R5 R10 R1: sample count is floor(len/4), zero for empty packets
            check($sformatf("R5/R10 vec%0d sample count", v), 32'(strobe_cnt - s0), {24'd0, VECS[v].exp_n});
            check($sformatf("R4 vec%0d drop count", v), 32'(drop_cnt - d0), {31'd0, VECS[v].exp_drop});
            check($sformatf("R8 vec%0d no underrun", v), 32'(under_cnt - u0), 32'd0);
            check($sformatf("R6 vec%0d ctrl words", v), 32'(ctrl_cnt - c0),
                  (VECS[v].kind == 2'd3) ? 32'(PKT_WORDS) : 32'd0);
            if (VECS[v].kind == 2'd3) begin
                check("R6 ctrl sop count", 32'(sop_cnt - p0), 32'd1);
                check("R6 ctrl eop count", 32'(eop_cnt - e0), 32'd1);
            end
            for (int i = 0; i < int'(VECS[v].exp_n); i++)
                check($sformatf("R5 vec%0d data %0d", v, i), log_d[s0 + i], {8'(v), 24'(i)});
            if (VECS[v].exp_n != 8'd0) begin
                if (VECS[v].kind == 2'd0)
                    check($sformatf("R2 vec%0d first sample time", v), log_t[s0], ts);
                else
                    check($sformatf("R3 vec%0d now plays at next enable", v), log_t[s0],
                          tnow - 32'd1 - 32'(strobe_cnt - s0 - 1));
            end
        end

        // R8: back-to-back packets inside a burst play with no gap
        sync_enable();
        s0 = strobe_cnt; u0 = under_cnt;
        send_pkt(mk_hdr(1'b1, 1'b0, 5'd3, 9'd8), 32'hFFFF_FFFF, 8'hA0);
        send_pkt(mk_hdr(1'b0, 1'b1, 5'd3, 9'd8), 32'hFFFF_FFFF, 8'hA1);
        repeat (3) @(negedge clk);
        check("R8 burst sample count", 32'(strobe_cnt - s0), 32'd4);
        check("R8 burst no underrun", 32'(under_cnt - u0), 32'd0);
        check("R8 burst contiguous", log_t[s0 + 3] - log_t[s0], 32'd3);
        check("R8 second packet data", log_d[s0 + 2], {8'hA1, 24'd0});
        repeat (4 * SE_PER) @(negedge clk);
        check("R8 silent after end of burst", 32'(under_cnt - u0), 32'd0);

        // R7: open burst starved of samples reports each enable
        sync_enable();
        send_pkt(mk_hdr(1'b1, 1'b0, 5'd3, 9'd4), 32'hFFFF_FFFF, 8'hB0);
        u0 = under_cnt;
        for (int k = 0; k < 3; k++) sync_enable();
        repeat (2) @(negedge clk);
        check("R7 underrun per starved enable", 32'(under_cnt - u0), 32'd3);

        // R9: reset closes the open burst
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 ready after mid-burst reset", {31'd0, in_ready}, 32'd1);
        u0 = under_cnt;
        for (int k = 0; k < 3; k++) sync_enable();
        repeat (2) @(negedge clk);
        check("R9 no underrun after reset", 32'(under_cnt - u0), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule